// File: doc/BRIEF.md
# Store Lane Formatter

This block sits between the address generation stage of a load/store pipeline and a 64-bit data write port. For every store request it takes the byte address, a store opcode, the endianness mode, a flag that enables 64-bit operations and the 64-bit source register. It returns the address of the 8-byte bus beat, the write data already placed in its byte lanes, a per-lane write strobe and two fault flags. The result is registered, so it appears one clock after the request.

Besides the naturally sized stores of 1, 2, 4 and 8 bytes, the block formats the four partial stores used for unaligned data: word-left, word-right, doubleword-left and doubleword-right. These write an endian-dependent slice of the register into the aligned word or doubleword that holds the address. The block does not read the memory. It raises strobes only on the bytes that a read-modify-write of that container would change, and it places the right register bytes in those lanes. Memory, caches and address translation are outside the block.

Top module: `stx_store_align`

## Requirements
- R1: The outputs are registered. `out_valid` is `req_valid` delayed by one clock. While `out_valid` is low, `out_strb`, `out_addr_err` and `out_rsvd_err` are zero. Reset clears all outputs.
- R2: Opcode codes are 0 byte, 1 halfword, 2 word, 3 doubleword, 4 word-left, 5 word-right, 6 doubleword-left and 7 doubleword-right. Codes 8 to 15 are undefined. Lane k is `out_data[8k+7:8k]` and `out_strb[k]`, and it holds the byte at `out_addr + k`. `out_addr` is `req_addr` with bits 2:0 cleared.
- R3: A naturally sized store writes the low bytes of the register to the bytes of its own size at the address, with every one of those strobes set. In little-endian mode (`req_big_endian`=0) the least significant byte goes to the lowest address. In big-endian mode the most significant stored byte goes to the lowest address. A halfword with address bit 0 set raises `out_addr_err`. So does a word with bits 1:0 not zero, and a doubleword with bits 2:0 not zero.
- R4: A byte store never raises an address error and sets exactly one strobe.
- R5: Word-left. Let i be address bits 1:0, XORed with 3 in little-endian mode. The result equals bits (31-8i)..0 of the aligned word, as seen in the current endianness, replaced by register bits 31..8i. The strobes cover exactly 4-i bytes.
- R6: Word-right. Let i be address bits 1:0, XORed with 3 in big-endian mode. Word bits 31..8i are replaced by register bits (31-8i)..0. The strobes cover exactly 4-i bytes.
- R7: Doubleword-left. Let i be address bits 2:0, XORed with 7 in little-endian mode. Doubleword bits (63-8i)..0 are replaced by register bits 63..8i. The strobes cover exactly 8-i bytes.
- R8: Doubleword-right. Let i be address bits 2:0, XORed with 7 in big-endian mode. Doubleword bits 63..8i are replaced by register bits (63-8i)..0. The strobes cover exactly 8-i bytes.
- R9: The four partial stores never raise `out_addr_err`, whatever the low address bits are.
- R10: `out_rsvd_err` is raised for opcodes 3, 6 and 7 when `req_wide_en` is 0, and for the undefined opcodes 8 to 15.
- R11: Whenever `out_addr_err` or `out_rsvd_err` is set, all strobes are zero. Both flags can be set in the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Store request present |
| req_op | input | 4 | Store opcode (see R2) |
| req_addr | input | AW | Byte address |
| req_big_endian | input | 1 | 1 = big-endian mode |
| req_wide_en | input | 1 | 1 = 64-bit operations allowed |
| req_data | input | 64 | Source register value |
| out_valid | output | 1 | Formatted beat present |
| out_addr | output | AW | 8-byte aligned beat address |
| out_data | output | 64 | Lane-placed write data |
| out_strb | output | 8 | Byte-lane write strobes |
| out_addr_err | output | 1 | Alignment fault |
| out_rsvd_err | output | 1 | Reserved-operation fault |

## Verification
The alignment check and the 64-bit gating check are separate paths, and both can fire in the same beat. The bench provokes this with a misaligned doubleword while 64-bit operations are disabled. It expects both flags set and no strobe. Each partial store is swept over every low address value in both endian modes, against a random old doubleword. The strobes and lane data are merged into that old value, and the result is compared with a read-modify-write reference computed in the bench. Popcount and beat address are checked as well.

// File: rtl/stx_pkg.sv
package stx_pkg;
    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES);

    localparam logic [3:0] OP_BYTE  = 4'd0;
    localparam logic [3:0] OP_HALF  = 4'd1;
    localparam logic [3:0] OP_WORD  = 4'd2;
    localparam logic [3:0] OP_DWORD = 4'd3;
    localparam logic [3:0] OP_WLEFT = 4'd4;
    localparam logic [3:0] OP_WRGHT = 4'd5;
    localparam logic [3:0] OP_DLEFT = 4'd6;
    localparam logic [3:0] OP_DRGHT = 4'd7;

    typedef enum logic [1:0] {
        KIND_FULL  = 2'd0,
        KIND_LEFT  = 2'd1,
        KIND_RIGHT = 2'd2
    } stx_kind_e;

    // container size in bytes from its log2
    function automatic logic [3:0] unit_bytes(input logic [1:0] szl);
        return 4'd1 << szl;
    endfunction
endpackage

// File: rtl/stx_decode.sv
module stx_decode
    import stx_pkg::*;
(
    input  logic [3:0]       op,
    input  logic [OFS_W-1:0] ofs,
    input  logic             wide_en,
    output stx_kind_e        kind,
    output logic [1:0]       szl,
    output logic             aerr,
    output logic             rerr
);
    always_comb begin
        kind = KIND_FULL;
        szl  = 2'd0;
        aerr = 1'b0;
        rerr = 1'b0;
        case (op)
            OP_BYTE: szl = 2'd0;
            OP_HALF: begin
                szl  = 2'd1;
                aerr = ofs[0];
            end
            OP_WORD: begin
                szl  = 2'd2;
                aerr = |ofs[1:0];
            end
            OP_DWORD: begin
                szl  = 2'd3;
                aerr = |ofs;
                rerr = !wide_en;
            end
            OP_WLEFT: begin
                kind = KIND_LEFT;
                szl  = 2'd2;
            end
            OP_WRGHT: begin
                kind = KIND_RIGHT;
                szl  = 2'd2;
            end
            OP_DLEFT: begin
                kind = KIND_LEFT;
                szl  = 2'd3;
                rerr = !wide_en;
            end
            OP_DRGHT: begin
                kind = KIND_RIGHT;
                szl  = 2'd3;
                rerr = !wide_en;
            end
            default: rerr = 1'b1;
        endcase
    end
endmodule

// File: rtl/stx_slice.sv
module stx_slice
    import stx_pkg::*;
(
    input  stx_kind_e         kind,
    input  logic [1:0]        szl,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] val,
    output logic [LANES-1:0]  vmask
);
    logic [3:0]       nbytes;
    logic [OFS_W-1:0] wmask;
    logic [LANES-1:0] lowmask;
    logic [OFS_W-1:0] off_in;
    logic             flip;
    logic [OFS_W-1:0] idx;
    logic [OFS_W+2:0] shamt;

    always_comb begin
        nbytes  = unit_bytes(szl);
        wmask   = OFS_W'(nbytes - 4'd1);
        lowmask = LANES'((9'd1 << nbytes) - 9'd1);
        off_in  = ofs & wmask;
        unique case (kind)
            KIND_LEFT:  flip = !big_endian;
            KIND_RIGHT: flip = big_endian;
            default:    flip = 1'b0;
        endcase
        idx   = (kind == KIND_FULL) ? '0 : (flip ? (off_in ^ wmask) : off_in);
        shamt = {idx, 3'b000};
        unique case (kind)
            KIND_LEFT: begin
                val   = data >> shamt;
                vmask = lowmask >> idx;
            end
            KIND_RIGHT: begin
                val   = data << shamt;
                vmask = (lowmask << idx) & lowmask;
            end
            default: begin
                val   = data;
                vmask = lowmask;
            end
        endcase
    end
endmodule

// File: rtl/stx_lane_map.sv
module stx_lane_map
    import stx_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic [LANES-1:0]  vmask,
    input  logic [1:0]        szl,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              big_endian,
    output logic [DATA_W-1:0] lane_data,
    output logic [LANES-1:0]  lane_strb
);
    logic [3:0]       nbytes;
    logic [OFS_W-1:0] wmask;
    logic [3:0]       base;

    always_comb begin
        nbytes = unit_bytes(szl);
        wmask  = OFS_W'(nbytes - 4'd1);
        base   = {1'b0, ofs & ~wmask};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0]       rel;
        logic             inr;
        logic [OFS_W-1:0] j;
        always_comb begin
            rel = 4'(k) - base;
            inr = (4'(k) >= base) && (rel < nbytes);
            j   = big_endian ? (wmask - rel[OFS_W-1:0]) : rel[OFS_W-1:0];
            lane_data[8*k +: 8] = val[{j, 3'b000} +: 8];
            lane_strb[k]        = inr & vmask[j];
        end
    end
endmodule

// File: rtl/stx_store_align.sv
module stx_store_align
    import stx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_big_endian,
    input  logic              req_wide_en,
    input  logic [DATA_W-1:0] req_data,
    output logic              out_valid,
    output logic [AW-1:0]     out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb,
    output logic              out_addr_err,
    output logic              out_rsvd_err
);
    localparam int HI_W = AW - OFS_W;

    stx_kind_e         kind;
    logic [1:0]        szl;
    logic              aerr;
    logic              rerr;
    logic [DATA_W-1:0] val;
    logic [LANES-1:0]  vmask;
    logic [DATA_W-1:0] lane_data;
    logic [LANES-1:0]  lane_strb;

    logic              nx_valid;
    logic [AW-1:0]     nx_addr;
    logic [DATA_W-1:0] nx_data;
    logic [LANES-1:0]  nx_strb;
    logic              nx_aerr;
    logic              nx_rerr;

    stx_decode u_decode (
        .op      (req_op),
        .ofs     (req_addr[OFS_W-1:0]),
        .wide_en (req_wide_en),
        .kind    (kind),
        .szl     (szl),
        .aerr    (aerr),
        .rerr    (rerr)
    );

    stx_slice u_slice (
        .kind       (kind),
        .szl        (szl),
        .ofs        (req_addr[OFS_W-1:0]),
        .big_endian (req_big_endian),
        .data       (req_data),
        .val        (val),
        .vmask      (vmask)
    );

    stx_lane_map u_map (
        .val        (val),
        .vmask      (vmask),
        .szl        (szl),
        .ofs        (req_addr[OFS_W-1:0]),
        .big_endian (req_big_endian),
        .lane_data  (lane_data),
        .lane_strb  (lane_strb)
    );

    // next-beat values
    always_comb begin
        nx_valid = req_valid;
        nx_addr  = '0;
        nx_data  = '0;
        nx_strb  = '0;
        nx_aerr  = 1'b0;
        nx_rerr  = 1'b0;
        if (req_valid) begin
            nx_addr = {req_addr[AW-1:OFS_W], {OFS_W{1'b0}}};
            nx_data = lane_data;
            nx_aerr = aerr;
            nx_rerr = rerr;
            nx_strb = (aerr || rerr) ? '0 : lane_strb;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_addr     <= '0;
            out_data     <= '0;
            out_strb     <= '0;
            out_addr_err <= 1'b0;
            out_rsvd_err <= 1'b0;
        end else begin
            out_valid    <= nx_valid;
            out_addr     <= nx_addr;
            out_data     <= nx_data;
            out_strb     <= nx_strb;
            out_addr_err <= nx_aerr;
            out_rsvd_err <= nx_rerr;
        end
    end

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/stx_store_align_chk.sv
module stx_store_align_chk
    import stx_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic [AW-1:0]     req_addr,
    input logic              req_wide_en,
    input logic              out_valid,
    input logic [AW-1:0]     out_addr,
    input logic [LANES-1:0]  out_strb,
    input logic              out_addr_err,
    input logic              out_rsvd_err
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (out_strb == '0 && !out_addr_err && !out_rsvd_err)); // R1
    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_addr[OFS_W-1:0] == '0); // R2
    AST_HALF_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == OP_HALF && req_addr[0]) |=> out_addr_err); // R3
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == OP_BYTE) |=> (!out_addr_err && $countones(out_strb) == 1)); // R4
    AST_PARTIAL_NO_AERR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op >= OP_WLEFT && req_op <= OP_DRGHT) |=> !out_addr_err); // R9
    AST_WIDE_GATED: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_wide_en && (req_op == OP_DWORD || req_op == OP_DLEFT || req_op == OP_DRGHT)) |=> out_rsvd_err); // R10
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (out_addr_err || out_rsvd_err) |-> out_strb == '0); // R11
endmodule

bind stx_store_align stx_store_align_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wide_en  (req_wide_en),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_strb     (out_strb),
    .out_addr_err (out_addr_err),
    .out_rsvd_err (out_rsvd_err)
);

// File: tb/stx_store_align_bench.sv
module stx_store_align_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_big_endian = 1'b0;
    logic          req_wide_en = 1'b1;
    logic [63:0]   req_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic [63:0]   out_data;
    logic [7:0]    out_strb;
    logic          out_addr_err;
    logic          out_rsvd_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    stx_store_align #(.AW(AW)) u_stx_store_align (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_big_endian(req_big_endian),
        .req_wide_en(req_wide_en), .req_data(req_data), .out_valid(out_valid),
        .out_addr(out_addr), .out_data(out_data), .out_strb(out_strb),
        .out_addr_err(out_addr_err), .out_rsvd_err(out_rsvd_err)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int op_size(input logic [3:0] op);
        case (op)
            4'd0: return 1;
            4'd1: return 2;
            4'd2, 4'd4, 4'd5: return 4;
            default: return 8;
        endcase
    endfunction

    // read-modify-write reference on one 8-byte beat (lane k = byte k)
    function automatic logic [63:0] ref_mem(input logic [63:0] old, input logic [3:0] op,
                                            input logic [2:0] a, input logic be, input logic [63:0] r);
        int s = op_size(op);
        int off = int'(a) - (int'(a) % s);
        int i;
        logic [63:0] c = '0;
        logic [63:0] res = old;
        for (int j = 0; j < s; j++) c[j*8 +: 8] = old[(off + (be ? s-1-j : j))*8 +: 8];
        case (op)
            4'd4: begin
                i = (int'(a) % 4) ^ (be ? 0 : 3);
                for (int b = 0; b <= 31 - 8*i; b++) c[b] = r[b + 8*i];
            end
            4'd5: begin
                i = (int'(a) % 4) ^ (be ? 3 : 0);
                for (int b = 8*i; b <= 31; b++) c[b] = r[b - 8*i];
            end
            4'd6: begin
                i = int'(a) ^ (be ? 0 : 7);
                for (int b = 0; b <= 63 - 8*i; b++) c[b] = r[b + 8*i];
            end
            4'd7: begin
                i = int'(a) ^ (be ? 7 : 0);
                for (int b = 8*i; b <= 63; b++) c[b] = r[b - 8*i];
            end
            default: for (int b = 0; b < s*8; b++) c[b] = r[b];
        endcase
        for (int j = 0; j < s; j++) res[(off + (be ? s-1-j : j))*8 +: 8] = c[j*8 +: 8];
        return res;
    endfunction

    function automatic int exp_count(input logic [3:0] op, input logic [2:0] a, input logic be);
        case (op)
            4'd4: return 4 - ((int'(a) % 4) ^ (be ? 0 : 3));
            4'd5: return 4 - ((int'(a) % 4) ^ (be ? 3 : 0));
            4'd6: return 8 - (int'(a) ^ (be ? 0 : 7));
            4'd7: return 8 - (int'(a) ^ (be ? 7 : 0));
            default: return op_size(op);
        endcase
    endfunction

    task automatic do_store(input string tag, input logic [3:0] op, input logic [AW-1:0] addr,
                            input logic be, input logic wide, input logic [63:0] r, input logic [63:0] old);
        logic ea;
        logic er;
        logic [63:0] got;
        logic [63:0] expm;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_big_endian = be; req_wide_en = wide; req_data = r;
        @(negedge clk);
        req_valid = 1'b0;
        ea = (op == 4'd1 && addr[0]) || (op == 4'd2 && addr[1:0] != 0) || (op == 4'd3 && addr[2:0] != 0);
        er = (op > 4'd7) || (!wide && (op == 4'd3 || op == 4'd6 || op == 4'd7));
        check(tag, "valid", 64'(out_valid), 64'd1);
        check(tag, "addr_err", 64'(out_addr_err), 64'(ea));
        check(tag, "rsvd_err", 64'(out_rsvd_err), 64'(er));
        check(tag, "beat addr", 64'(out_addr), 64'({addr[AW-1:3], 3'b000}));
        got = old;
        for (int k = 0; k < 8; k++) if (out_strb[k]) got[k*8 +: 8] = out_data[k*8 +: 8];
        if (ea || er) begin
            check(tag, "strobes on fault", 64'(out_strb), 64'd0); // R11
        end else begin
            expm = ref_mem(old, op, addr[2:0], be, r);
            check(tag, "merged beat", got, expm);
            check(tag, "strobe count", 64'($countones(out_strb)), 64'(exp_count(op, addr[2:0], be)));
        end
    endtask

    task automatic t_reset();
        // R1: reset clears outputs
        check("R1", "reset valid", 64'(out_valid), 64'd0);
        check("R1", "reset strobes", 64'(out_strb), 64'd0);
        check("R1", "reset flags", 64'({out_addr_err, out_rsvd_err}), 64'd0);
    endtask

    task automatic t_idle();
        do_store("R1", 4'd2, 32'h100, 1'b0, 1'b1, 64'h1122334455667788, 64'h0);
        @(negedge clk);
        check("R1", "idle valid", 64'(out_valid), 64'd0);
        check("R1", "idle strobes", 64'(out_strb), 64'd0);
    endtask

    task automatic t_full();
        for (int be = 0; be < 2; be++)
            for (int op = 0; op < 4; op++)
                for (int a = 0; a < 8; a += op_size(4'(op)))
                    do_store(op == 0 ? "R4" : "R3", 4'(op), 32'h2000 + 32'(a), 1'(be), 1'b1,
                             64'hF1E2D3C4B5A69788 ^ 64'(a), 64'h0123456789ABCDEF);
    endtask

    task automatic t_faults();
        do_store("R3", 4'd1, 32'h31, 1'b0, 1'b1, 64'hAAAA, 64'h55);
        do_store("R3", 4'd2, 32'h32, 1'b1, 1'b1, 64'hBBBB, 64'h66);
        do_store("R3", 4'd3, 32'h34, 1'b0, 1'b1, 64'hCCCC, 64'h77);
        do_store("R4", 4'd0, 32'h37, 1'b1, 1'b1, 64'hDD, 64'h88);
    endtask

    task automatic t_partial(input logic [3:0] op, input string tag);
        for (int be = 0; be < 2; be++)
            for (int a = 0; a < 8; a++)
                do_store(tag, op, 32'h4000 + 32'(a), 1'(be), 1'b1,
                         64'h8877665544332211 + 64'(a * 3), 64'hC3A5F00F5A3CE719 ^ {8{8'(a)}});
    endtask

    task automatic t_reserved();
        do_store("R10", 4'd3, 32'h50, 1'b0, 1'b0, 64'h1, 64'h0);
        do_store("R10", 4'd6, 32'h53, 1'b1, 1'b0, 64'h2, 64'h0);
        do_store("R10", 4'd7, 32'h55, 1'b0, 1'b0, 64'h3, 64'h0);
        do_store("R10", 4'd9, 32'h58, 1'b0, 1'b1, 64'h4, 64'h0);
        do_store("R10", 4'd15, 32'h58, 1'b1, 1'b1, 64'h5, 64'h0);
        do_store("R9", 4'd4, 32'h53, 1'b0, 1'b0, 64'h6, 64'h0);
    endtask

    task automatic t_both_faults();
        // R11: alignment and 64-bit gating in the same beat
        do_store("R11", 4'd3, 32'h65, 1'b1, 1'b0, 64'hFFFF, 64'h1234);
        check("R11", "both flags", 64'({out_addr_err, out_rsvd_err}), 64'd3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_full();
        t_faults();
        t_partial(4'd4, "R5");
        t_partial(4'd5, "R6");
        t_partial(4'd6, "R7");
        t_partial(4'd7, "R8");
        t_partial(4'd4, "R9");
        t_reserved();
        t_both_faults();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule